// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block takes a 32-bit write to a software interrupt trigger register and turns it into per-processor pending state. The written word names one of sixteen software interrupts and a way of choosing destinations. The destinations can be an explicit processor list, every online processor except the writer, or the writer alone. For every destination chosen, the named interrupt becomes pending on that processor, and the writer's own bit is recorded in a per-interrupt source mask.

State is kept for each destination processor and each interrupt: a pending flag and a source mask with one bit per possible requester. An acknowledge path clears one requester bit from one interrupt on one target. The pending flag falls when the last requester bit is gone. Reads of the trigger register always return zero. Arbitration and delivery to a processor interface happen elsewhere.

Top module: `sgi_dispatch`

## Requirements
- R1: While reset is asserted and on its release, every pending flag and every source bit is zero.
- R2: The interrupt number is wr_data[3:0] and the target mode is wr_data[25:24]. Mode 0 takes its destinations from the list in wr_data[23:16], where bit 16+n selects processor n. All other bits of the word have no effect.
- R3: Mode 1 selects every processor whose index is below online_cnt, except the requesting processor.
- R4: Mode 2 selects only the requesting processor and ignores the list field.
- R5: A write in mode 3 changes no pending flag and no source bit.
- R6: A processor whose index is at or above online_cnt is never marked, even when the list selects it.
- R7: For each selected target, the interrupt becomes pending and bit req_cpu of its source mask is set. Earlier source bits are kept. The new state is visible on the outputs from the clock edge that samples wr_en.
- R8: rd_data reads as zero at all times.
- R9: A clear removes bit clr_src from the mask of interrupt clr_sgi on target clr_tgt. The pending flag drops exactly when that mask becomes zero and stays set otherwise.
- R10: When a write and a clear reach the same cell in one cycle, the clear is applied first and the set second, so a set of the same source bit wins.
- R11: pend_o bit (t*16+s) is the flag of interrupt s on target t. src_o bits [(t*16+s)*8 +: 8] hold its source mask, with bit k meaning requester k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe for the trigger register |
| wr_data | input | 32 | Written word |
| req_cpu | input | 3 | Index of the processor issuing the write |
| online_cnt | input | 4 | Number of online processors, 1 to 8 |
| rd_data | output | 32 | Read value of the trigger register, always zero |
| clr_en | input | 1 | Acknowledge clear strobe |
| clr_tgt | input | 3 | Target processor of the clear |
| clr_sgi | input | 4 | Interrupt number of the clear |
| clr_src | input | 3 | Requester bit to remove |
| pend_o | output | 128 | Pending flags, layout per R11 |
| src_o | output | 1024 | Source masks, layout per R11 |

## Verification
The properties assume that req_cpu is below online_cnt and that online_cnt stays between 1 and 8 while a write is made. The stimulus always picks the requester from the online processors and changes the online count only between operations. The properties on untouched targets are only enabled when no clear is in flight, because a clear may legally change any cell. The stimulus therefore runs most writes with clr_en low and keeps a few simultaneous write-and-clear cases for the ordering rule.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  // Field positions of the trigger word
  localparam int ID_LSB   = 0;
  localparam int LIST_LSB = 16;
  localparam int MODE_LSB = 24;

  typedef enum logic [1:0] {
    TGT_LIST   = 2'd0,
    TGT_OTHERS = 2'd1,
    TGT_SELF   = 2'd2,
    TGT_RSVD   = 2'd3
  } sgi_mode_e;
endpackage

// File: rtl/sgi_tgt_decode.sv
module sgi_tgt_decode
  import sgi_pkg::*;
#(
  parameter int NCPU  = 8,
  parameter int CPU_W = 3,
  parameter int CNT_W = 4
) (
  input  logic [31:0]      wdata,
  input  logic [CPU_W-1:0] req,
  input  logic [CNT_W-1:0] online,
  output logic [NCPU-1:0]  tgt_mask
);
  logic [NCPU-1:0] in_rng;
  logic [NCPU-1:0] req_oh;
  logic [NCPU-1:0] raw;
  sgi_mode_e       mode;

  assign mode   = sgi_mode_e'(wdata[MODE_LSB +: 2]);
  assign req_oh = {{(NCPU-1){1'b0}}, 1'b1} << req;

  always_comb begin
    for (int t = 0; t < NCPU; t++) begin
      in_rng[t] = (CNT_W'(t) < online);
    end
  end

  always_comb begin
    unique case (mode)
      TGT_LIST:   raw = wdata[LIST_LSB +: NCPU];
      TGT_OTHERS: raw = ~req_oh;
      TGT_SELF:   raw = req_oh;
      default:    raw = '0;
    endcase
  end

  // processors beyond the online count are never selected
  assign tgt_mask = raw & in_rng;
endmodule

// File: rtl/sgi_cell.sv
module sgi_cell #(
  parameter int NCPU = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_hit,
  input  logic [NCPU-1:0] set_oh,
  input  logic            clr_hit,
  input  logic [NCPU-1:0] clr_oh,
  output logic            pend,
  output logic [NCPU-1:0] src
);
  logic [NCPU-1:0] src_nx;
  logic            pend_nx;
  logic            upd;

  assign upd = set_hit | clr_hit;

  // clear first, then set
  always_comb begin
    src_nx = src;
    if (clr_hit) src_nx = src_nx & ~clr_oh;
    if (set_hit) src_nx = src_nx | set_oh;
    pend_nx = pend;
    if (set_hit)                     pend_nx = 1'b1;
    else if (clr_hit && src_nx == '0) pend_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src  <= '0;
      pend <= 1'b0;
    end else if (upd) begin
      src  <= src_nx;
      pend <= pend_nx;
    end
  end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch #(
  parameter int NCPU  = 8,
  parameter int NSGI  = 16,
  parameter int CPU_W = $clog2(NCPU),
  parameter int ID_W  = $clog2(NSGI),
  parameter int CNT_W = $clog2(NCPU) + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [31:0]               wr_data,
  input  logic [CPU_W-1:0]          req_cpu,
  input  logic [CNT_W-1:0]          online_cnt,
  output logic [31:0]               rd_data,
  input  logic                      clr_en,
  input  logic [CPU_W-1:0]          clr_tgt,
  input  logic [ID_W-1:0]           clr_sgi,
  input  logic [CPU_W-1:0]          clr_src,
  output logic [NCPU*NSGI-1:0]      pend_o,
  output logic [NCPU*NSGI*NCPU-1:0] src_o
);
  localparam int NCELL = NCPU * NSGI;

  logic [NCPU-1:0] tgt_mask;
  logic [NCPU-1:0] req_oh;
  logic [NCPU-1:0] clr_oh;
  logic [ID_W-1:0] wr_id;

  assign rd_data = '0;
  assign wr_id   = wr_data[ID_W-1:0];
  assign req_oh  = {{(NCPU-1){1'b0}}, 1'b1} << req_cpu;
  assign clr_oh  = {{(NCPU-1){1'b0}}, 1'b1} << clr_src;

  sgi_tgt_decode #(
    .NCPU (NCPU),
    .CPU_W(CPU_W),
    .CNT_W(CNT_W)
  ) u_dec (
    .wdata   (wr_data),
    .req     (req_cpu),
    .online  (online_cnt),
    .tgt_mask(tgt_mask)
  );

  for (genvar t = 0; t < NCPU; t++) begin : g_tgt
    for (genvar s = 0; s < NSGI; s++) begin : g_sgi
      localparam int IDX = t * NSGI + s;
      logic set_hit;
      logic clr_hit;
      assign set_hit = wr_en & tgt_mask[t] & (wr_id == ID_W'(s));
      assign clr_hit = clr_en & (clr_tgt == CPU_W'(t)) & (clr_sgi == ID_W'(s));

      sgi_cell #(.NCPU(NCPU)) u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_hit(set_hit),
        .set_oh (req_oh),
        .clr_hit(clr_hit),
        .clr_oh (clr_oh),
        .pend   (pend_o[IDX]),
        .src    (src_o[IDX*NCPU +: NCPU])
      );
    end
  end

  if (NCELL < 1) begin : g_bad
    initial $error("sgi_dispatch: empty configuration");
  end
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
  parameter int NCPU  = 8,
  parameter int NSGI  = 16,
  parameter int CPU_W = 3,
  parameter int ID_W  = 4,
  parameter int CNT_W = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [31:0]               wr_data,
  input logic [CPU_W-1:0]          req_cpu,
  input logic [CNT_W-1:0]          online_cnt,
  input logic [31:0]               rd_data,
  input logic                      clr_en,
  input logic [CPU_W-1:0]          clr_tgt,
  input logic [ID_W-1:0]           clr_sgi,
  input logic [CPU_W-1:0]          clr_src,
  input logic [NCPU*NSGI-1:0]      pend_o,
  input logic [NCPU*NSGI*NCPU-1:0] src_o
);
  localparam int BLK = NSGI * NCPU;
  logic [1:0] mode;
  assign mode = wr_data[25:24];

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pend_o == '0 && src_o == '0));

  a_r5_reserved_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode == 2'd3 && !clr_en) |=> ($stable(pend_o) && $stable(src_o)));

  a_r7_sources_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> (($past(src_o) & ~src_o) == '0));

  for (genvar c = 0; c < NCPU*NSGI; c++) begin : g_cell
    a_r9_pend_tracks_src: assert property (@(posedge clk) disable iff (!rst_n)
      pend_o[c] == (|src_o[c*NCPU +: NCPU]));
  end

  for (genvar t = 0; t < NCPU; t++) begin : g_tgt
    a_r6_offline_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr_en && (CNT_W'(t) >= online_cnt)) |=> $stable(src_o[t*BLK +: BLK]));
    a_r3_requester_skipped: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr_en && mode == 2'd1 && req_cpu == CPU_W'(t)) |=> $stable(src_o[t*BLK +: BLK]));
    a_r4_self_only: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr_en && mode == 2'd2 && req_cpu != CPU_W'(t)) |=> $stable(src_o[t*BLK +: BLK]));
  end
endmodule

bind sgi_dispatch sgi_dispatch_chk #(
  .NCPU (NCPU),
  .NSGI (NSGI),
  .CPU_W(CPU_W),
  .ID_W (ID_W),
  .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/sim_sgi_dispatch.sv
module sim_sgi_dispatch;
  localparam int NCPU = 8;
  localparam int NSGI = 16;
  localparam int NP   = NCPU * NSGI;
  localparam int NS   = NP * NCPU;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, clr_en;
  logic [31:0]   wr_data, rd_data;
  logic [2:0]    req_cpu, clr_tgt, clr_src;
  logic [3:0]    online_cnt, clr_sgi;
  logic [NP-1:0] pend_o;
  logic [NS-1:0] src_o;

  typedef struct {
    logic [NP-1:0] pend;
    logic [NS-1:0] src;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  logic [NCPU-1:0] m_src [NCPU][NSGI];

  always #2 clk = ~clk;

  sgi_dispatch u0 (.*);

  function automatic exp_t snap(string tag);
    exp_t e;
    e.tag = tag;
    for (int t = 0; t < NCPU; t++)
      for (int s = 0; s < NSGI; s++) begin
        e.src[(t*NSGI+s)*NCPU +: NCPU] = m_src[t][s];
        e.pend[t*NSGI+s] = (m_src[t][s] != '0);
      end
    return e;
  endfunction

  // driver: applies one operation, updates the model, pushes expectation
  task automatic op(bit we, logic [31:0] wd, int req, int onl,
                    bit ce, int ct, int cs, int cr, string tag);
    logic [NCPU-1:0] tg;
    int id, md;
    @(negedge clk);
    wr_en = we; wr_data = wd; req_cpu = 3'(req); online_cnt = 4'(onl);
    clr_en = ce; clr_tgt = 3'(ct); clr_sgi = 4'(cs); clr_src = 3'(cr);
    id = int'(wd[3:0]); md = int'(wd[25:24]);
    tg = '0;
    for (int t = 0; t < NCPU; t++) begin
      if (t < onl) begin
        if (md == 0) tg[t] = wd[16+t];
        if (md == 1) tg[t] = (t != req);
        if (md == 2) tg[t] = (t == req);
      end
    end
    if (ce) m_src[ct][cs][cr] = 1'b0;
    if (we)
      for (int t = 0; t < NCPU; t++)
        if (tg[t]) m_src[t][id][req] = 1'b1;
    @(posedge clk);
    #1;
    wr_en = 1'b0; clr_en = 1'b0;
    q.push_back(snap(tag));
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      n_run++;
      if (pend_o !== e.pend || src_o !== e.src) begin
        n_fail++;
        $display("FAIL %s pend=%h exp=%h src=%h exp=%h", e.tag, pend_o, e.pend, src_o, e.src);
      end
      n_run++;
      if (rd_data !== 32'h0) begin
        n_fail++;
        $display("FAIL R8 rd_data=%h exp=0", rd_data);
      end
    end
  end

  initial begin
    #(4*100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < NCPU; t++)
      for (int s = 0; s < NSGI; s++) m_src[t][s] = '0;
    rst_n = 1'b0; wr_en = 1'b0; clr_en = 1'b0; wr_data = '0;
    req_cpu = '0; online_cnt = 4'd8; clr_tgt = '0; clr_sgi = '0; clr_src = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    q.push_back(snap("R1 reset"));
    // R2 list mode, cpus 0 and 2, id 3
    op(1, 32'h0005_0003, 1, 4, 0, 0, 0, 0, "R2 list mode");
    // R6 list selects cpu 6 while only 4 online
    op(1, 32'h0041_0005, 0, 4, 0, 0, 0, 0, "R6 offline ignored");
    // R3 others, req 2, 5 online, id 7
    op(1, 32'h0100_0007, 2, 5, 0, 0, 0, 0, "R3 all but self");
    // R4 self, list full, req 3
    op(1, 32'h02FF_0000, 3, 8, 0, 0, 0, 0, "R4 self only");
    // R5 reserved mode
    op(1, 32'h03FF_0009, 1, 8, 0, 0, 0, 0, "R5 reserved");
    // R7 second requester on same cell (cpu0, id3)
    op(1, 32'h0001_0003, 3, 4, 0, 0, 0, 0, "R7 source or");
    // R2 stray bits in other fields
    op(1, 32'hFC05_FFF4, 0, 8, 0, 0, 0, 0, "R2 stray bits");
    // R9 clear one of two sources: pending stays
    op(0, 32'h0, 0, 8, 1, 0, 3, 1, "R9 partial clear");
    // R9 clear last source: pending drops
    op(0, 32'h0, 0, 8, 1, 0, 3, 3, "R9 last clear");
    // R9 clear of an absent bit
    op(0, 32'h0, 0, 8, 1, 5, 9, 2, "R9 absent clear");
    // R10 write and clear same cell and source: set wins
    op(1, 32'h0010_0008, 2, 8, 1, 4, 8, 2, "R10 set wins");
    // R10 clear one source while another sets the same cell
    op(1, 32'h0010_0008, 5, 8, 1, 4, 8, 2, "R10 clear then set");
    // R3 full count, req 7
    op(1, 32'h0100_000F, 7, 8, 0, 0, 0, 0, "R3 eight online");
    // R11 layout: single bit target 7, id 15
    op(1, 32'h0080_000F, 6, 8, 0, 0, 0, 0, "R11 layout");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule